// File: doc/BRIEF.md
# Edge-Interval Input Capture Unit

This block times the gaps between chosen edges of an asynchronous input pin. The pin is brought into the clock domain by a two-stage synchronizer. A third stage keeps the previous sample so that rising and falling transitions can be seen. An interval counter runs while capture is active. On each selected edge, the elapsed cycle count (its low 26 bits) is pushed into a small FIFO and the counter starts over.

A programmable limit ends a measurement that runs too long. When the counter reaches the limit, it stops there, a timeout flag is raised and nothing is pushed. The next edge restarts the counter without pushing an entry.

Four sticky status flags report a timeout, a detected edge, a FIFO holding at least half its depth, and a capture lost to a full FIFO. Each flag is cleared by writing 1 to its clear bit. The interrupt line is the OR of the flags whose enable bit is set. Software reads the oldest entry from `rd_data` and removes it by pulsing `rd_en`.

Top module: `edge_capture`

## Requirements
- R1: After reset, `fifo_count` is 0, `rd_data` is 0, `flags` is 0 and `irq` is 0.
- R2: With `edge_sel` = 1 (both edges), every transition of `cap_in` pushes one entry. The entry equals the number of clock cycles since the previous detected edge.
- R3: With `edge_sel` = 2 (falling to falling), only falling transitions push. Each entry is the number of cycles between two consecutive falling edges.
- R4: With `edge_sel` = 3 (rising to rising), only rising transitions push. Each entry is the number of cycles between two consecutive rising edges.
- R5: When `mode_cap` = 0, `run` = 0 or `edge_sel` = 0, edges push no entry and set no flag.
- R6: When the interval counter reaches `cnt_end`:
  - the counter holds at that value;
  - `flags[0]` is set;
  - no entry is pushed.
  The next selected edge sets `flags[1]`, pushes nothing and restarts the interval.
- R7: Entries leave in arrival order. `rd_data` shows the oldest entry, or 0 when the FIFO is empty. A pulse on `rd_en` while the FIFO is empty leaves `fifo_count` at 0.
- R8: `flags[2]` is set in every cycle in which capture mode is on and the FIFO holds 4 or more entries. If it is cleared while that condition holds, it is set again one cycle later.
- R9: An edge that would push while the FIFO is full (DEPTH = 8 entries) and no pop occurs has two effects:
  - it sets `flags[3]`;
  - it is dropped, so `fifo_count` and the stored entries do not change.
- R10: Writing 1 to a bit of `flag_clr` clears that flag on the next clock edge. `irq` is high whenever any bit of `flags & irq_en` is 1.
- R11: A transition on `cap_in` raises `fifo_count` exactly three rising clock edges after it is applied, and not after two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_in | input | 1 | Asynchronous input that is measured |
| mode_cap | input | 1 | 1 selects capture operation, 0 selects timer operation (no capture) |
| run | input | 1 | Counter enable |
| edge_sel | input | 2 | Edge mode: 0 off, 1 both, 2 falling to falling, 3 rising to rising |
| cnt_end | input | 32 | Timeout limit for the interval counter |
| rd_en | input | 1 | Pops the oldest FIFO entry |
| rd_data | output | 26 | Oldest FIFO entry, or 0 when the FIFO is empty |
| fifo_count | output | 4 | Number of stored entries |
| flag_clr | input | 4 | Write-1-to-clear strobes, one bit per flag |
| irq_en | input | 4 | Interrupt enable, one bit per flag |
| flags | output | 4 | Bit 0 timeout, bit 1 edge seen, bit 2 half full, bit 3 overflow |
| irq | output | 1 | OR of the enabled flags |

## Verification
The hardest situation to reach is a capture that arrives while the FIFO is full and no pop is pending. Reaching it needs eight valid intervals in a row, with no read in between. The bench reaches it by applying nine transitions at growing spacings while never asserting `rd_en`. It then drains the FIFO, which confirms that the dropped ninth interval did not disturb the order or values of the stored ones. The timeout case needs a long gap between edges, followed by an edge that must not push. The bench reaches it by lowering `cnt_end` and waiting well beyond that limit.

// File: rtl/edge_capture.sv
module edge_capture #(
  parameter int CW    = 32,
  parameter int DW    = 26,
  parameter int DEPTH = 8,
  parameter int HALF  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_in,
  input  logic              mode_cap,
  input  logic              run,
  input  logic [1:0]        edge_sel,
  input  logic [CW-1:0]     cnt_end,
  input  logic              rd_en,
  output logic [DW-1:0]     rd_data,
  output logic [$clog2(DEPTH):0] fifo_count,
  input  logic [3:0]        flag_clr,
  input  logic [3:0]        irq_en,
  output logic [3:0]        flags,
  output logic              irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int NW = AW + 1;

  logic [2:0]    sync;
  logic [CW-1:0] cnt;
  logic          sat;
  logic          ev;
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  wire active = mode_cap & run & (edge_sel != 2'd0);
  wire rise   = sync[1] & ~sync[2];
  wire fall   = ~sync[1] & sync[2];

  always_comb begin
    case (edge_sel)
      2'd1:    ev = rise | fall;
      2'd2:    ev = fall;
      2'd3:    ev = rise;
      default: ev = 1'b0;
    endcase
  end

  wire hit    = active & ev;
  wire push   = hit & ~sat;
  wire empty  = fifo_count == NW'(0);
  wire full   = fifo_count == NW'(DEPTH);
  wire pop    = rd_en & ~empty;
  wire wr     = push & (~full | pop);
  wire ovf    = push & full & ~pop;
  wire to_set = active & ~hit & ~sat & (cnt == cnt_end);
  wire hf_set = mode_cap & (fifo_count >= NW'(HALF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= '0;
    else        sync <= {sync[1:0], cap_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sat <= 1'b0;
    end else if (!active) begin
      cnt <= '0;
      sat <= 1'b0;
    end else if (hit) begin
      cnt <= CW'(1);
      sat <= 1'b0;
    end else if (cnt == cnt_end) begin
      sat <= 1'b1;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (wr) mem[wptr] <= cnt[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr       <= '0;
      rptr       <= '0;
      fifo_count <= '0;
    end else begin
      if (wr)  wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + AW'(1);
      if (pop) rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + AW'(1);
      fifo_count <= fifo_count + NW'(wr) - NW'(pop);
    end
  end

  assign rd_data = empty ? '0 : mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags | {ovf, hf_set, hit, to_set}) & ~flag_clr;
  end

  assign irq = |(flags & irq_en);

  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= NW'(DEPTH));

  p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty && !hit) |=> fifo_count == '0);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[3]) |-> $past(fifo_count) == NW'(DEPTH));

  p_drop_keeps_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !rd_en) |=> $stable(fifo_count));

  p_sat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sat && active && !hit) |=> $stable(cnt));

  p_idle_no_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> fifo_count <= $past(fifo_count));
endmodule

// File: tb/test_edge_capture.sv
module test_edge_capture;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cap_in = 0;
  logic        mode_cap = 0;
  logic        run = 0;
  logic [1:0]  edge_sel = 0;
  logic [31:0] cnt_end = 32'hFFFF_FFFF;
  logic        rd_en = 0;
  logic [25:0] rd_data;
  logic [3:0]  fifo_count;
  logic [3:0]  flag_clr = 0;
  logic [3:0]  irq_en = 0;
  logic [3:0]  flags;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_capture i_edge_capture (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .mode_cap(mode_cap), .run(run),
    .edge_sel(edge_sel), .cnt_end(cnt_end), .rd_en(rd_en), .rd_data(rd_data),
    .fifo_count(fifo_count), .flag_clr(flag_clr), .irq_en(irq_en),
    .flags(flags), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cap_in = 0; mode_cap = 0; run = 0; edge_sel = 0;
    cnt_end = 32'hFFFF_FFFF; rd_en = 0; flag_clr = 0; irq_en = 0;
    wait_cyc(2);
    rst_n = 1;
    wait_cyc(1);
  endtask

  task automatic pop();
    rd_en = 1; wait_cyc(1); rd_en = 0;
  endtask

  task automatic clr(input logic [3:0] m);
    flag_clr = m; wait_cyc(1); flag_clr = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 count", fifo_count, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 flags", flags, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_both();
    do_reset();
    mode_cap = 1; run = 1; edge_sel = 1;
    wait_cyc(2);
    cap_in = 1;
    wait_cyc(2);
    chk("R11 not after two", fifo_count, 0);
    wait_cyc(1);
    chk("R11 after three", fifo_count, 1);
    pop();
    wait_cyc(3);
    cap_in = 0;
    wait_cyc(5);
    cap_in = 1;
    wait_cyc(4);
    chk("R2 count", fifo_count, 2);
    chk("R2 first interval", rd_data, 7);
    pop();
    chk("R2 second interval", rd_data, 5);
    chk("R2 edge flag", flags[1], 1);
  endtask

  task automatic t_fall();
    do_reset();
    mode_cap = 1; run = 1; edge_sel = 2;
    wait_cyc(2);
    cap_in = 1; wait_cyc(4);
    chk("R3 rise ignored", fifo_count, 0);
    cap_in = 0; wait_cyc(4);
    cap_in = 1; wait_cyc(6);
    cap_in = 0; wait_cyc(4);
    chk("R3 count", fifo_count, 2);
    pop();
    chk("R3 interval", rd_data, 10);
  endtask

  task automatic t_rise();
    do_reset();
    mode_cap = 1; run = 1; edge_sel = 3;
    wait_cyc(2);
    cap_in = 1; wait_cyc(3);
    cap_in = 0; wait_cyc(9);
    cap_in = 1; wait_cyc(4);
    chk("R4 count", fifo_count, 2);
    pop();
    chk("R4 interval", rd_data, 12);
  endtask

  task automatic t_idle();
    do_reset();
    mode_cap = 0; run = 1; edge_sel = 1;
    cap_in = 1; wait_cyc(4); cap_in = 0; wait_cyc(4);
    chk("R5 timer mode count", fifo_count, 0);
    chk("R5 timer mode flags", flags, 0);
    mode_cap = 1; edge_sel = 0;
    cap_in = 1; wait_cyc(4); cap_in = 0; wait_cyc(4);
    chk("R5 edge off count", fifo_count, 0);
    edge_sel = 1; run = 0;
    cap_in = 1; wait_cyc(4); cap_in = 0; wait_cyc(4);
    chk("R5 stopped count", fifo_count, 0);
    chk("R5 stopped flags", flags, 0);
  endtask

  task automatic t_timeout();
    do_reset();
    mode_cap = 1; run = 1; edge_sel = 1; cnt_end = 20;
    wait_cyc(2);
    cap_in = 1; wait_cyc(10);
    cap_in = 0; wait_cyc(5);
    chk("R6 no early timeout", flags[0], 0);
    wait_cyc(35);
    chk("R6 timeout flag", flags[0], 1);
    chk("R6 no push on timeout", fifo_count, 2);
    clr(4'b0010);
    chk("R10 edge flag cleared", flags[1], 0);
    cap_in = 1; wait_cyc(4);
    chk("R6 edge after timeout no push", fifo_count, 2);
    chk("R6 edge flag after timeout", flags[1], 1);
    wait_cyc(6);
    cap_in = 0; wait_cyc(4);
    chk("R6 restart push", fifo_count, 3);
    pop();
    chk("R6 stored interval", rd_data, 10);
    pop();
    chk("R6 restarted interval", rd_data, 10);
  endtask

  task automatic t_fill();
    do_reset();
    mode_cap = 1; run = 1; edge_sel = 1; irq_en = 4'b1000;
    wait_cyc(2);
    for (int i = 0; i < 8; i++) begin
      cap_in = ~cap_in;
      wait_cyc(4 + i);
    end
    chk("R9 full count", fifo_count, 8);
    chk("R9 no overflow yet", flags[3], 0);
    chk("R10 irq low", irq, 0);
    chk("R8 half flag", flags[2], 1);
    cap_in = ~cap_in; wait_cyc(4);
    chk("R9 dropped count", fifo_count, 8);
    chk("R9 overflow flag", flags[3], 1);
    chk("R10 irq high", irq, 1);
    clr(4'b0100);
    chk("R8 half cleared", flags[2], 0);
    wait_cyc(1);
    chk("R8 half reasserted", flags[2], 1);
    clr(4'b1000);
    wait_cyc(1);
    chk("R10 overflow cleared", flags[3], 0);
    chk("R10 irq after clear", irq, 0);
    pop();
    for (int k = 1; k < 8; k++) begin
      chk("R7 order", rd_data, k + 3);
      pop();
    end
    chk("R7 drained", fifo_count, 0);
    chk("R7 empty data", rd_data, 0);
    pop();
    chk("R7 empty pop", fifo_count, 0);
    chk("R7 empty data after pop", rd_data, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_both();
    t_fall();
    t_rise();
    t_idle();
    t_timeout();
    t_fill();
    finish_run();
  end
endmodule